// File: doc/BRIEF.md
# Prioritized Status LED Blink Encoder

This block drives one green status LED on an FPGA module so that a person looking at the board can tell which fault, if any, is present. Five fault conditions arrive as level inputs: the active-low connector reset, the power enable, a power-fault flag, the FPGA initialization status and the FPGA configured flag. Each fault has its own repeating eight-slot on/off signature. Only the most important active fault is shown.

A free-running slot timer splits time into slots of a fixed length. An eight-slot index wraps continuously. The chosen fault class is taken up only at a slot boundary, so a change of condition never cuts a slot short. When no fault is present, the LED follows a user signal coming from the FPGA fabric.

Every input passes through a two-stage synchronizer. The LED output comes straight from a flip-flop, and a 1 turns the LED on.

Top module: `status_led_encoder`

## Requirements
- R1: While the synchronized connector reset (`conn_rst_n`) is 0, the displayed class lights the LED in all eight slots, so the LED stays on continuously.
- R2: When R1 does not apply and `pwr_en` is 0, the LED is on in slots 0 to 4 and off in slots 5 to 7.
- R3: When R1 and R2 do not apply and `pwr_fault` is 1, the LED is on in slots 0 to 3 and off in slots 4 to 7.
- R4: When R1 to R3 do not apply and `fpga_init_n` is 0, the LED is on in slots 0 to 2 and off in slots 3 to 7.
- R5: When R1 to R4 do not apply and `fpga_done` is 0, the LED is on in slot 0 only.
- R6: When no fault applies, `led` equals `fpga_user` as it was three clock edges earlier.
- R7: Only the highest-priority active condition sets the pattern. Priority runs from R1 (highest) down to R5, and lower conditions have no effect on `led`.
- R8: A slot lasts CLK_HZ/1000*SLOT_MS clock cycles. The slot index counts 0 to 7, wraps from 7 back to 0, and keeps running whatever the inputs do.
- R9: A change in the selected class is taken up only at the last cycle of a slot, so it first shows in the LED at the start of the next slot.
- R10: Every input crosses two flip-flops before use, so a change at an input cannot reach `led` in fewer than three clock edges.
- R11: While `rst_n` is 0 and right after it is released, `led` is 0, the slot index is 0 and no fault class is displayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| conn_rst_n | input | 1 | Connector reset, active low (fault R1) |
| pwr_en | input | 1 | Power enable, 0 is fault R2 |
| pwr_fault | input | 1 | Power fault flag, 1 is fault R3 |
| fpga_init_n | input | 1 | FPGA initialization status, 0 is fault R4 |
| fpga_done | input | 1 | FPGA configured flag, 0 is fault R5 |
| fpga_user | input | 1 | User LED value from the fabric |
| led | output | 1 | LED drive, 1 is on |

## Verification
The bench builds the block with CLK_HZ=4000 and SLOT_MS=1, which gives four-cycle slots and a 32-cycle pattern. At that size every signature, the 7-to-0 wrap and many slot boundaries fit within a few hundred cycles. Condition changes are placed in the middle of slots, so the boundary hold-off of R9 and the three-edge synchronizer latency of R10 both come into play. Each fault is also applied together with every lower-priority fault, which exercises R7.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  // Bit positions of the condition vector.
  localparam int C_CONN = 0;
  localparam int C_PWEN = 1;
  localparam int C_PFLT = 2;
  localparam int C_INIT = 3;
  localparam int C_DONE = 4;
  localparam int C_USER = 5;
  localparam int IN_W   = 6;

  // Value of the input vector when no fault is present and the user bit is 0.
  localparam logic [IN_W-1:0] IDLE_VEC = 6'b011011;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_HOLD   = 3'd1,
    CLS_NOEN   = 3'd2,
    CLS_PFAIL  = 3'd3,
    CLS_NOINIT = 3'd4,
    CLS_UNCONF = 3'd5
  } led_class_e;

  // Return the highest-priority fault class present in the condition bits.
  function automatic led_class_e pick_class(input logic [IN_W-1:0] c);
    if (!c[C_CONN])      return CLS_HOLD;
    else if (!c[C_PWEN]) return CLS_NOEN;
    else if (c[C_PFLT])  return CLS_PFAIL;
    else if (!c[C_INIT]) return CLS_NOINIT;
    else if (!c[C_DONE]) return CLS_UNCONF;
    return CLS_NONE;
  endfunction

  // Number of lit slots, counted from slot 0, for each fault class.
  function automatic logic [SLOT_W:0] lit_slots(input led_class_e k);
    case (k)
      CLS_HOLD:   return (SLOT_W+1)'(8);
      CLS_NOEN:   return (SLOT_W+1)'(5);
      CLS_PFAIL:  return (SLOT_W+1)'(4);
      CLS_NOINIT: return (SLOT_W+1)'(3);
      CLS_UNCONF: return (SLOT_W+1)'(1);
      default:    return '0;
    endcase
  endfunction

  // LED value for a given class and slot index.
  function automatic logic pattern_bit(input led_class_e k,
                                       input logic [SLOT_W-1:0] slot,
                                       input logic user);
    if (k == CLS_NONE) return user;
    return ({1'b0, slot} < lit_slots(k));
  endfunction

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int              W         = 1,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RESET_VAL[i];
        stab_q <= RESET_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import status_led_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              slot_tick,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam int CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0]     cyc_q;
  logic [SLOT_W-1:0] slot_q;

  assign slot_tick = (cyc_q == LAST);
  assign slot_idx  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (slot_tick) begin
      cyc_q  <= '0;
      slot_q <= slot_q + SLOT_W'(1);
    end else begin
      cyc_q  <= cyc_q + CW'(1);
    end
  end
endmodule

// File: rtl/class_latch.sv
module class_latch
  import status_led_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_tick,
  input  logic [IN_W-1:0] cond,
  output led_class_e      want_class,
  output led_class_e      cur_class
);
  assign want_class = pick_class(cond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_class <= CLS_NONE;
    else if (slot_tick) cur_class <= want_class;
  end
endmodule

// File: rtl/led_driver.sv
module led_driver
  import status_led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  led_class_e        cur_class,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              user,
  output logic              led
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led <= 1'b0;
    else        led <= pattern_bit(cur_class, slot_idx, user);
  end
endmodule

// File: rtl/status_led_encoder.sv
module status_led_encoder
  import status_led_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int SLOT_MS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_rst_n,
  input  logic pwr_en,
  input  logic pwr_fault,
  input  logic fpga_init_n,
  input  logic fpga_done,
  input  logic fpga_user,
  output logic led
);
  localparam int SLOT_CYCLES = CLK_HZ / 1000 * SLOT_MS;

  logic [IN_W-1:0]   raw_vec, sync_vec;
  logic              slot_tick;
  logic [SLOT_W-1:0] slot_idx;
  led_class_e        want_class, cur_class;

  assign raw_vec = {fpga_user, fpga_done, fpga_init_n, pwr_fault, pwr_en, conn_rst_n};

  level_sync #(.W(IN_W), .RESET_VAL(IDLE_VEC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(sync_vec)
  );

  slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .slot_idx(slot_idx)
  );

  class_latch u_class (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .cond(sync_vec),
    .want_class(want_class), .cur_class(cur_class)
  );

  led_driver u_drv (
    .clk(clk), .rst_n(rst_n), .cur_class(cur_class), .slot_idx(slot_idx),
    .user(sync_vec[C_USER]), .led(led)
  );
endmodule

// File: rtl/status_led_checker.sv
module status_led_checker
  import status_led_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_tick,
  input logic [SLOT_W-1:0] slot_idx,
  input led_class_e        want_class,
  input led_class_e        cur_class,
  input logic              led
);
  localparam int CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) + 1 : 2;
  logic [CW-1:0] since_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         since_tick <= '0;
    else if (slot_tick) since_tick <= '0;
    else                since_tick <= since_tick + CW'(1);
  end

  p_tick_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |-> (since_tick == CW'(SLOT_CYCLES - 1)));
  p_no_late_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    since_tick <= CW'(SLOT_CYCLES - 1));
  p_slot_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && slot_idx == 3'd7) |=> (slot_idx == 3'd0));
  p_slot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(slot_idx));
  p_class_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(cur_class));
  p_class_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> (cur_class == $past(want_class)));
  p_hold_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_class == CLS_HOLD) |=> led);
  p_noen_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_class == CLS_NOEN && slot_idx < 3'd5) |=> led);
  p_unconf_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_class == CLS_UNCONF && slot_idx != 3'd0) |=> !led);
endmodule

bind status_led_encoder status_led_checker #(.SLOT_CYCLES(CLK_HZ / 1000 * SLOT_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .slot_idx(slot_idx),
  .want_class(want_class), .cur_class(cur_class), .led(led)
);

// File: tb/sim_status_led_encoder.sv
module sim_status_led_encoder;
  localparam int  CLK_PERIOD = 10;
  localparam int  S          = 4;      // slot length with CLK_HZ=4000, SLOT_MS=1
  localparam int  LIMIT      = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  // bit order: user, done, init_n, pwr_fault, pwr_en, conn_rst_n
  logic [5:0] vin = 6'b011011;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic led;
  status_led_encoder #(.CLK_HZ(4000), .SLOT_MS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .conn_rst_n(vin[0]), .pwr_en(vin[1]),
    .pwr_fault(vin[2]), .fpga_init_n(vin[3]), .fpga_done(vin[4]),
    .fpga_user(vin[5]), .led(led)
  );

  // ---------------- behavioural reference ----------------
  logic [5:0] hist[$];
  int  m_n, m_cls;
  logic m_led;

  function automatic int prio(input logic [5:0] v);
    if (v[0] == 1'b0) return 1;
    if (v[1] == 1'b0) return 2;
    if (v[2] == 1'b1) return 3;
    if (v[3] == 1'b0) return 4;
    if (v[4] == 1'b0) return 5;
    return 0;
  endfunction

  function automatic logic lit(input int k, input int slot, input logic u);
    int on;
    case (k)
      1: on = 8; 2: on = 5; 3: on = 4; 4: on = 3; 5: on = 1;
      default: return u;
    endcase
    return slot < on;
  endfunction

  function automatic string tag(input int k);
    case (k)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; default: return "R6";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete(); m_n = 0; m_cls = 0; m_led = 1'b0;
    end else begin
      logic [5:0] late;
      logic nl;
      late = (hist.size() >= 2) ? hist[hist.size()-2] : 6'b011011;
      nl = lit(m_cls, (m_n / S) % 8, late[5]);
      if (m_n % S == S - 1) m_cls = prio(late);   // R9 boundary take-up, R8 slot length
      m_led = nl;
      hist.push_back(vin);
      if (hist.size() > 4) void'(hist.pop_front());
      m_n++;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: led=%b expected %b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // advance n cycles, comparing with the reference at every falling edge
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      if (rst_n) check(tag(m_cls), led, m_led);
    end
  endtask

  task automatic window(input string req, input int exp_on);
    int on = 0;
    for (int i = 0; i < 8 * S; i++) begin
      @(negedge clk); cyc++;
      if (led) on++;
    end
    checks++;
    if (on != exp_on) begin
      fails++;
      $display("FAIL %s: lit cycles per pattern=%0d expected %0d", req, on, exp_on);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R11", led, 1'b0);                   // R11 reset state
    rst_n = 1'b1;
    run(1);
    check("R11", led, 1'b0);
    run(40);
    // R10: user edge needs three edges to reach the LED
    vin[5] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R10", led, 1'b0);
    @(posedge clk); #1;
    check("R10", led, 1'b1);
    @(negedge clk);
    // R6 user toggling
    for (int i = 0; i < 12; i++) begin vin[5] = ~vin[5]; run(3 + i % 4); end
    vin[5] = 1'b0;
    run(10);
    // R5 done low, changed mid-slot (R9)
    vin[4] = 1'b0; run(66); window("R5", 1 * S);
    // R4 + lower (R7)
    vin[3] = 1'b0; run(65); window("R4", 3 * S);
    // R3 + lower (R7)
    vin[2] = 1'b1; run(67); window("R3", 4 * S);
    // R2 + lower (R7), user high must not matter
    vin[1] = 1'b0; vin[5] = 1'b1; run(66); window("R2", 5 * S);
    // R1 with all others active
    vin[0] = 1'b0; run(65); window("R1", 8 * S);
    // R7: lower faults clear while R1 holds: still continuous
    vin = 6'b011010; run(64); window("R7", 8 * S);
    // back to idle: R6 mirror of user, mid-slot release
    vin = 6'b111011; run(70); window("R6", 8 * S);
    vin[5] = 1'b0; run(40); window("R6", 0);
    // R11 block reset mid-run
    vin[4] = 1'b0; run(20);
    rst_n = 1'b0; @(negedge clk); check("R11", led, 1'b0);
    rst_n = 1'b1; run(100);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end
endmodule